// File: doc/BRIEF.md
# Audio Sample-Rate Strobe Generator

This block turns a fast core clock into three one-cycle enable strobes. The strobes pace the audio converters, the serial audio port and the signal-processing engine. First a base sampling period is formed by counting core cycles, and the number of cycles is picked by an oversampling-ratio field. Each of the three consumers then picks its own multiple or fraction of that base period. The three choices are independent of each other.

The control fields are plain inputs, normally driven from a clock-control register. One bit chooses between a direct external clock and a synthesizer output. With the synthesizer selected the core clock always runs at 1024 times the base rate, so the ratio field is overridden. A core-enable bit gates the whole block. Any change to the configuration restarts the counter chain, so a strobe never has a period that mixes old and new settings.

All strobe periods come from one half-period prescaler and three small per-consumer counters. This lets the 0.5x and 1.5x fractional divisors produce exact integer periods.

Top module: `samprate_strobe_gen`

## Requirements
- R1: While `rst_n` is low, all three strobes are low.
- R2: The base period in core cycles is (`cfg_ratio_sel` + 1) × `RATIO_UNIT`. With the default `RATIO_UNIT` of 256, the codes 0, 1, 2 and 3 give 256, 512, 768 and 1024 cycles.
- R3: When `cfg_src_pll` is 1, the base period is 4 × `RATIO_UNIT` whatever value `cfg_ratio_sel` holds.
- R4: A rate-select code of 0, 1, 2, 3, 4, 5 or 6 multiplies the base period by 0.5, 1, 1.5, 2, 3, 4 or 6. Each strobe then repeats with exactly that period.
- R5: Any other rate-select code behaves like code 1 (multiplier 1). For the 3-bit selects that is code 7, and for the 4-bit DSP select it is codes 7 to 15.
- R6: Each strobe is high for exactly one core cycle at a time.
- R7: While `cfg_core_en` is 0, no strobe is produced and the counters are held at zero.
- R8: When any configuration input changes value, the counters restart. The first strobe of period P then appears P cycles after the cycle in which the change was presented, and none appears before it.
- R9: The three strobes use their own rate-select codes, and setting one does not alter the period of another.
- R10: After `cfg_core_en` rises, the first strobe of period P appears P cycles after the cycle in which enable rose.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_core | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_src_pll | input | 1 | Clock source: 0 direct, 1 synthesizer (forces ratio code 3) |
| cfg_ratio_sel | input | 2 | Base oversampling ratio code |
| cfg_core_en | input | 1 | Core enable; 0 stops all strobes |
| conv_rate_sel | input | 3 | Converter rate code |
| sport_rate_sel | input | 3 | Serial-port rate code |
| dsp_rate_sel | input | 4 | DSP rate code |
| conv_stb | output | 1 | Converter sample strobe |
| sport_stb | output | 1 | Serial-port sample strobe |
| dsp_stb | output | 1 | DSP sample strobe |

## Verification
The bench builds one instance with `RATIO_UNIT` = 4, so base periods shrink to 4 to 16 cycles. This makes it practical to run all four ratio codes against all seven rate codes on every output, and to cover forced-source mode, invalid codes, restarts and enable gating. A second instance keeps the default of 256 and confirms full-scale periods of 512, 1024 and 6144 cycles with the synthesizer source forced.

// File: rtl/samprate_pkg.sv
package samprate_pkg;

    typedef logic [3:0] halves_t;

    // Strobe period expressed in half base periods for a rate-select code.
    function automatic halves_t rate_halves(input logic [3:0] code);
        case (code)
            4'd0:    rate_halves = 4'd1;
            4'd1:    rate_halves = 4'd2;
            4'd2:    rate_halves = 4'd3;
            4'd3:    rate_halves = 4'd4;
            4'd4:    rate_halves = 4'd6;
            4'd5:    rate_halves = 4'd8;
            4'd6:    rate_halves = 4'd12;
            default: rate_halves = 4'd2;
        endcase
    endfunction

endpackage

// File: rtl/cfg_watch.sv
module cfg_watch #(
    parameter int CFG_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_now,
    input  logic             core_en,
    output logic             restart
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cfg = cfg_now;
        restart  = !core_en || (cfg_now != st_q.cfg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: one cycle after a restart, the stored copy matches what was presented
    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_now != st_q.cfg) |=> (st_q.cfg == $past(cfg_now)));
endmodule

// File: rtl/half_prescaler.sv
module half_prescaler #(
    parameter int RATIO_UNIT = 256,
    localparam int HW = $clog2(2 * RATIO_UNIT + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       src_pll,
    input  logic [1:0] ratio_sel,
    output logic       half_tick
);
    typedef struct packed {
        logic [HW-1:0] cnt;
    } state_t;

    state_t        st_d, st_q;
    logic [1:0]    eff_sel;
    logic [HW-1:0] halves;
    logic          wrap;

    always_comb begin
        eff_sel   = src_pll ? 2'd3 : ratio_sel;
        halves    = HW'((int'(eff_sel) + 1) * (RATIO_UNIT / 2));
        wrap      = (st_q.cnt == halves - HW'(1));
        half_tick = wrap && !restart;
        st_d      = st_q;
        if (restart)   st_d.cnt = '0;
        else if (wrap) st_d.cnt = '0;
        else           st_d.cnt = st_q.cnt + HW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: counter never passes its current half-period limit
    p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (st_q.cnt < halves));
    // R8: a restart leaves the counter at zero
    p_pre_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));
endmodule

// File: rtl/rate_tap.sv
module rate_tap
    import samprate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       half_tick,
    input  logic [3:0] rate_sel,
    output logic       strobe
);
    typedef struct packed {
        halves_t cnt;
    } state_t;

    state_t  st_d, st_q;
    halves_t mult;
    logic    last;

    always_comb begin
        mult   = rate_halves(rate_sel);
        last   = (st_q.cnt == mult - 4'd1);
        strobe = half_tick && last;
        st_d   = st_q;
        if (restart)        st_d.cnt = '0;
        else if (half_tick) st_d.cnt = last ? '0 : st_q.cnt + 4'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: a strobe is never followed directly by another
    p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
    // R4: the tap count stays below the selected multiple
    p_tap_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (st_q.cnt < mult));
endmodule

// File: rtl/samprate_strobe_gen.sv
module samprate_strobe_gen #(
    parameter int RATIO_UNIT = 256
) (
    input  logic       clk_core,
    input  logic       rst_n,
    input  logic       cfg_src_pll,
    input  logic [1:0] cfg_ratio_sel,
    input  logic       cfg_core_en,
    input  logic [2:0] conv_rate_sel,
    input  logic [2:0] sport_rate_sel,
    input  logic [3:0] dsp_rate_sel,
    output logic       conv_stb,
    output logic       sport_stb,
    output logic       dsp_stb
);
    localparam int NCONS = 3;
    localparam int CFG_W = 1 + 2 + 1 + 3 + 3 + 4;

    logic             restart;
    logic             half_tick;
    logic [CFG_W-1:0] cfg_now;
    logic [3:0]       sel_ext [NCONS];
    logic [NCONS-1:0] stb_vec;

    initial begin
        assert (RATIO_UNIT >= 4 && RATIO_UNIT % 2 == 0)
            else $error("RATIO_UNIT must be even and at least 4");
    end

    always_comb begin
        cfg_now    = {cfg_src_pll, cfg_ratio_sel, cfg_core_en,
                      conv_rate_sel, sport_rate_sel, dsp_rate_sel};
        sel_ext[0] = {1'b0, conv_rate_sel};
        sel_ext[1] = {1'b0, sport_rate_sel};
        sel_ext[2] = dsp_rate_sel;
    end

    cfg_watch #(.CFG_W(CFG_W)) u_watch (
        .clk     (clk_core),
        .rst_n   (rst_n),
        .cfg_now (cfg_now),
        .core_en (cfg_core_en),
        .restart (restart)
    );

    half_prescaler #(.RATIO_UNIT(RATIO_UNIT)) u_pre (
        .clk       (clk_core),
        .rst_n     (rst_n),
        .restart   (restart),
        .src_pll   (cfg_src_pll),
        .ratio_sel (cfg_ratio_sel),
        .half_tick (half_tick)
    );

    for (genvar g = 0; g < NCONS; g++) begin : g_tap
        rate_tap u_tap (
            .clk       (clk_core),
            .rst_n     (rst_n),
            .restart   (restart),
            .half_tick (half_tick),
            .rate_sel  (sel_ext[g]),
            .strobe    (stb_vec[g])
        );
    end

    assign conv_stb  = stb_vec[0];
    assign sport_stb = stb_vec[1];
    assign dsp_stb   = stb_vec[2];

    // R7: disabled core means silent outputs
    p_quiet_off_r7: assert property (@(posedge clk_core) disable iff (!rst_n)
        !cfg_core_en |-> (stb_vec == '0));
    // R8: no strobe in the cycle a new configuration is presented
    p_no_mixed_r8: assert property (@(posedge clk_core) disable iff (!rst_n)
        !$stable(cfg_now) |-> (stb_vec == '0));
    // R1: outputs low while held in reset
    always_comb begin
        if (!rst_n) p_reset_quiet_r1: assert (stb_vec == '0);
    end
endmodule

// File: tb/sim_samprate_strobe_gen.sv
module sim_samprate_strobe_gen;
    localparam int CLK_HALF = 5;
    localparam int UNIT     = 4;
    localparam int BIG_UNIT = 256;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src = 1'b0;
    logic [1:0] ratio = 2'd0;
    logic       en = 1'b0;
    logic [2:0] csel = 3'd0;
    logic [2:0] ssel = 3'd0;
    logic [3:0] dsel = 4'd0;
    logic       c0, s0, d0, c1, s1, d1;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #CLK_HALF clk = ~clk;

    samprate_strobe_gen #(.RATIO_UNIT(UNIT)) u0 (
        .clk_core(clk), .rst_n(rst_n), .cfg_src_pll(src), .cfg_ratio_sel(ratio),
        .cfg_core_en(en), .conv_rate_sel(csel), .sport_rate_sel(ssel),
        .dsp_rate_sel(dsel), .conv_stb(c0), .sport_stb(s0), .dsp_stb(d0));

    samprate_strobe_gen u1 (
        .clk_core(clk), .rst_n(rst_n), .cfg_src_pll(src), .cfg_ratio_sel(ratio),
        .cfg_core_en(en), .conv_rate_sel(csel), .sport_rate_sel(ssel),
        .dsp_rate_sel(dsel), .conv_stb(c1), .sport_stb(s1), .dsp_stb(d1));

    function automatic int exp_halves(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 4;
            4: return 6;
            5: return 8;
            6: return 12;
            default: return 2;
        endcase
    endfunction

    function automatic int exp_period(input int unit, input bit s, input int r, input int code);
        int base;
        base = (s ? 4 : r + 1) * unit;
        return base * exp_halves(code) / 2;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input bit s, input int r, input bit e, input int c, input int sp, input int d);
        @(negedge clk);
        src = s; ratio = 2'(r); en = e;
        csel = 3'(c); ssel = 3'(sp); dsel = 4'(d);
    endtask

    // Samples W cycles after the apply; strobes must fall exactly on multiples of each period.
    task automatic measure(input int p0, input int p1, input int p2, input int w,
                           input bit big, input string req);
        int per[3];
        int hits[3];
        bit bad[3];
        logic [2:0] sv;
        per = '{p0, p1, p2};
        hits = '{0, 0, 0};
        bad = '{1'b0, 1'b0, 1'b0};
        for (int i = 1; i <= w; i++) begin
            @(negedge clk);
            sv = big ? {d1, s1, c1} : {d0, s0, c0};
            for (int j = 0; j < 3; j++) begin
                if (sv[j]) begin
                    hits[j]++;
                    if (i % per[j] != 0) bad[j] = 1'b1;
                end
            end
        end
        for (int j = 0; j < 3; j++)
            check(!bad[j] && hits[j] == w / per[j],
                  $sformatf("%s out%0d period %0d", req, j, per[j]), hits[j], w / per[j]);
    endtask

    task automatic quiet(input int w, input string req);
        int hits;
        hits = 0;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            hits += int'(c0) + int'(s0) + int'(d0) + int'(c1) + int'(s1) + int'(d1);
        end
        check(hits == 0, req, hits, 0);
    endtask

    task automatic t_reset;
        src = 1'b0; ratio = 2'd0; en = 1'b1; csel = 3'd0; ssel = 3'd1; dsel = 4'd0;
        quiet(40, "R1 strobes during reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_sweep;
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 7; c++) begin
                int p0, p1, p2, mx;
                p0 = exp_period(UNIT, 1'b0, r, c);
                p1 = exp_period(UNIT, 1'b0, r, (c + 2) % 7);
                p2 = exp_period(UNIT, 1'b0, r, (c + 5) % 7);
                mx = p0 > p1 ? p0 : p1;
                mx = mx > p2 ? mx : p2;
                apply(1'b0, r, 1'b1, c, (c + 2) % 7, (c + 5) % 7);
                measure(p0, p1, p2, 2 * mx + 1, 1'b0, "R2/R4/R6/R8/R9 sweep");
            end
        end
    endtask

    task automatic t_pll_force;
        apply(1'b1, 0, 1'b1, 1, 0, 6);
        measure(exp_period(UNIT, 1'b1, 0, 1), exp_period(UNIT, 1'b1, 0, 0),
                exp_period(UNIT, 1'b1, 0, 6), 200, 1'b0, "R3 forced ratio code 0");
        apply(1'b1, 2, 1'b1, 1, 0, 6);
        measure(16, 8, 96, 200, 1'b0, "R3/R8 forced ratio code 2 restarts");
    endtask

    task automatic t_invalid;
        apply(1'b0, 1, 1'b1, 7, 7, 12);
        measure(8, 8, 8, 41, 1'b0, "R5 invalid codes act as multiplier 1");
        apply(1'b0, 1, 1'b1, 0, 3, 15);
        measure(4, 16, 8, 49, 1'b0, "R5/R9 mixed valid and invalid");
    endtask

    task automatic t_gating;
        apply(1'b0, 3, 1'b0, 0, 1, 2);
        quiet(150, "R7 no strobes while disabled");
        apply(1'b0, 3, 1'b1, 0, 1, 2);
        measure(8, 16, 24, 97, 1'b0, "R10 first strobe after enable");
        apply(1'b0, 3, 1'b0, 0, 1, 2);
        quiet(100, "R7 disable mid-run");
    endtask

    task automatic t_midrun;
        apply(1'b0, 2, 1'b1, 6, 6, 6);
        repeat (37) @(negedge clk);
        apply(1'b0, 0, 1'b1, 3, 4, 5);
        measure(8, 12, 16, 65, 1'b0, "R8 restart mid-period");
    endtask

    task automatic t_full_scale;
        apply(1'b1, 0, 1'b1, 1, 0, 6);
        measure(exp_period(BIG_UNIT, 1'b1, 0, 1), exp_period(BIG_UNIT, 1'b1, 0, 0),
                exp_period(BIG_UNIT, 1'b1, 0, 6), 12289, 1'b1, "R2/R3 default unit full scale");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                check(1'b0, "watchdog", cycles, WATCHDOG);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_sweep();
        t_pll_force();
        t_invalid();
        t_gating();
        t_midrun();
        t_full_scale();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule